// File: doc/BRIEF.md
# Bus-Matching Width Converter

This stage sits between an external data port of selectable width and a 36-bit internal queue word. On the write side it gathers 9-bit or 18-bit beats into a full 36-bit word and offers that word to the queue once the final beat arrives. On the read side it takes a 36-bit word from the queue and hands it out as 18-bit or 9-bit beats. A byte-order setting decides whether the most-significant or the least-significant slice of a word travels first.

Both directions use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. The width pairing and the byte order are latched only while master reset is held. A partial reset empties the data path but keeps the latched setting.

Top module: `bus_width_matcher`

## Requirements
- R1: `mode_sel` selects the width pairing: 3'b000 gives x36 in and x36 out, 3'b001 gives x9 in, 3'b010 gives x18 in, 3'b011 gives x18 out, and 3'b100 gives x9 out. The side not named stays x36. Every other code (3'b101, 3'b110, 3'b111) behaves as 3'b000.
- R2: In x9-in mode, four accepted beats form one word. `push_valid` is high only while the fourth beat is offered, and `push_data` then carries the complete word in that same cycle.
- R3: In x18-in mode, two accepted beats form one word, and only the second beat raises `push_valid`.
- R4: In x36 mode on a side, data passes through unchanged. `push_data` equals `in_data` in the cycle of the write. `out_data` equals the popped word one cycle after the pop.
- R5: In x18-out mode, each popped word yields two beats on `out_data`. `pop_ready` stays low until the second beat has been accepted.
- R6: In x9-out mode, each popped word yields four beats, and no new pop is taken before the fourth beat is accepted.
- R7: Beat order. With `big_endian`=1, beat 0 is the most-significant slice (bits 35:27 for x9, bits 35:18 for x18). With `big_endian`=0, beat 0 is the least-significant slice. Each later beat takes the next slice in that direction. The rule is the same for packing and for unpacking.
- R8: `mode_sel` and `big_endian` are latched only in cycles where `rst_n` is low. Changing them afterwards has no effect, and a partial reset (`prst_n` low) keeps the latched setting.
- R9: Either reset drops any partly gathered input word and any partly delivered output word. After reset, `push_valid` and `out_valid` are low, and `in_ready` and `pop_ready` are high.
- R10: While the last input beat waits on `push_ready`=0, `in_ready` is low and the gathering state holds. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R11: Narrow beats use the low bits of the data buses. Input bits above the beat width are ignored. Output bits above the beat width are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Master reset, active low, synchronous; latches the setting |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps the setting |
| mode_sel | input | 3 | Width pairing code |
| big_endian | input | 1 | Byte order: 1 sends the most-significant slice first |
| in_valid | input | 1 | External write beat present |
| in_ready | output | 1 | Write beat accepted this cycle |
| in_data | input | 36 | Write beat, low-aligned when narrow |
| push_valid | output | 1 | Full word offered to the queue |
| push_ready | input | 1 | Queue accepts the offered word |
| push_data | output | 36 | Word offered to the queue |
| pop_valid | input | 1 | Queue has a word available |
| pop_ready | output | 1 | Converter takes the queue word |
| pop_data | input | 36 | Word read from the queue |
| out_valid | output | 1 | Read beat present |
| out_ready | input | 1 | External reader takes the beat |
| out_data | output | 36 | Read beat, low-aligned and zero-filled when narrow |

## Verification
The write side has no register between the final beat and the queue. `push_valid` and `push_data` are therefore due in the same cycle as the last write beat, and the bench samples them one nanosecond after driving that beat at the falling edge. On the read side the first beat is due in the cycle after the pop edge, each later beat follows one cycle after the previous one is accepted, and `pop_ready` returns in the cycle after the last beat. The bench drives at falling edges and samples in the middle of the low phase, so each check reads the value produced by the previous rising edge.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int WORD_W = 36;
  localparam int LANE_W = 9;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int CNT_W  = $clog2(LANES);

  typedef enum logic [1:0] {W_FULL = 2'd0, W_HALF = 2'd1, W_QUARTER = 2'd2} width_e;

  typedef struct packed {
    width_e in_w;
    width_e out_w;
    logic   big_end;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [2:0] sel, input logic be);
    cfg_t c;
    c.big_end = be;
    case (sel)
      3'b001:  begin c.in_w = W_QUARTER; c.out_w = W_FULL;    end
      3'b010:  begin c.in_w = W_HALF;    c.out_w = W_FULL;    end
      3'b011:  begin c.in_w = W_FULL;    c.out_w = W_HALF;    end
      3'b100:  begin c.in_w = W_FULL;    c.out_w = W_QUARTER; end
      default: begin c.in_w = W_FULL;    c.out_w = W_FULL;    end
    endcase
    return c;
  endfunction

  function automatic int beats(input width_e w);
    case (w)
      W_QUARTER: return LANES;
      W_HALF:    return LANES / 2;
      default:   return 1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] last_idx(input width_e w);
    return CNT_W'(beats(w) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] beat_mask(input width_e w);
    return {WORD_W{1'b1}} >> (WORD_W - WORD_W / beats(w));
  endfunction

  // Bit offset of beat idx inside the word for the chosen order
  function automatic int beat_shift(input logic [CNT_W-1:0] idx, input width_e w,
                                    input logic be);
    int slot;
    slot = be ? (beats(w) - 1 - int'(idx)) : int'(idx);
    return slot * (WORD_W / beats(w));
  endfunction

  function automatic logic [WORD_W-1:0] place_beat(input logic [WORD_W-1:0] word,
                                                   input logic [WORD_W-1:0] beat,
                                                   input logic [CNT_W-1:0] idx,
                                                   input width_e w, input logic be);
    return word | ((beat & beat_mask(w)) << beat_shift(idx, w, be));
  endfunction

  function automatic logic [WORD_W-1:0] pick_beat(input logic [WORD_W-1:0] word,
                                                  input logic [CNT_W-1:0] idx,
                                                  input width_e w, input logic be);
    return (word >> beat_shift(idx, w, be)) & beat_mask(w);
  endfunction
endpackage

// File: rtl/bwm_config.sv
module bwm_config
  import bwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       big_endian,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= decode_cfg(mode_sel, big_endian);
  end

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg));
endmodule

// File: rtl/bwm_packer.sv
module bwm_packer
  import bwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  cfg_t              cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_data
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic              clear;
  logic              beat_last;
  logic              beat_take;
  logic [WORD_W-1:0] merged;

  assign clear      = !rst_n || !prst_n;
  assign beat_last  = (cnt == last_idx(cfg.in_w));
  assign merged     = place_beat(acc, in_data, cnt, cfg.in_w, cfg.big_end);
  assign in_ready   = !beat_last || push_ready;
  assign beat_take  = in_valid && in_ready;
  assign push_valid = in_valid && beat_last;
  assign push_data  = merged;

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
      acc <= '0;
    end else if (beat_take) begin
      if (beat_last) begin
        cnt <= '0;
        acc <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= merged;
      end
    end
  end

  assert_push_restarts_R2: assert property (@(posedge clk) disable iff (clear)
    (push_valid && push_ready) |=> (cnt == '0));
  assert_beat_advances_R3: assert property (@(posedge clk) disable iff (clear)
    (beat_take && !beat_last) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (clear)
    (in_valid && !in_ready) |=> ($stable(cnt) && $stable(acc)));
endmodule

// File: rtl/bwm_unpacker.sv
module bwm_unpacker
  import bwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  cfg_t              cfg,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [WORD_W-1:0] pop_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] hold;
  logic              hold_vld;
  logic [CNT_W-1:0]  idx;
  logic              clear;
  logic              pop_take;
  logic              beat_take;
  logic              beat_last;

  assign clear     = !rst_n || !prst_n;
  assign pop_ready = !hold_vld;
  assign pop_take  = pop_valid && pop_ready;
  assign out_valid = hold_vld;
  assign beat_last = (idx == last_idx(cfg.out_w));
  assign beat_take = out_valid && out_ready;
  assign out_data  = pick_beat(hold, idx, cfg.out_w, cfg.big_end);

  always_ff @(posedge clk) begin
    if (clear) begin
      hold     <= '0;
      hold_vld <= 1'b0;
      idx      <= '0;
    end else if (pop_take) begin
      hold     <= pop_data;
      hold_vld <= 1'b1;
      idx      <= '0;
    end else if (beat_take) begin
      if (beat_last) begin
        hold_vld <= 1'b0;
        idx      <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assert_pop_presents_R4: assert property (@(posedge clk) disable iff (clear)
    pop_take |=> (out_valid && idx == '0));
  assert_no_early_pop_R5: assert property (@(posedge clk) disable iff (clear)
    (out_valid && !(out_ready && beat_last)) |=> !pop_ready);
  assert_last_frees_R6: assert property (@(posedge clk) disable iff (clear)
    (beat_take && beat_last) |=> pop_ready);
  assert_out_holds_R10: assert property (@(posedge clk) disable iff (clear)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prst_n,
  input  logic [2:0]  mode_sel,
  input  logic        big_endian,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [35:0] in_data,
  output logic        push_valid,
  input  logic        push_ready,
  output logic [35:0] push_data,
  input  logic        pop_valid,
  output logic        pop_ready,
  input  logic [35:0] pop_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [35:0] out_data
);
  cfg_t cfg;

  bwm_config u_config (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .big_endian (big_endian),
    .cfg        (cfg)
  );

  bwm_packer u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .prst_n     (prst_n),
    .cfg        (cfg),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data)
  );

  bwm_unpacker u_unpacker (
    .clk       (clk),
    .rst_n     (rst_n),
    .prst_n    (prst_n),
    .cfg       (cfg),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_data  (pop_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assert_reset_idle_R9: assert property (@(posedge clk)
    (!rst_n || !prst_n) |=> (!out_valid && pop_ready));
endmodule

// File: tb/bus_width_matcher_bench.sv
module bus_width_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, prst_n = 1'b1;
  logic [2:0]  mode_sel = 3'b000;
  logic        big_endian = 1'b0;
  logic        in_valid = 1'b0, push_ready = 1'b1, pop_valid = 1'b0, out_ready = 1'b1;
  logic [35:0] in_data = '0, pop_data = '0;
  logic        in_ready, push_valid, pop_ready, out_valid;
  logic [35:0] push_data, out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_width_matcher u_bus_width_matcher (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .big_endian(big_endian), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // {mode[2:0], big_endian, word[35:0]}
  localparam logic [39:0] VEC [9] = '{
    {3'd1, 1'b1, 36'h9A5C3E1F7}, {3'd1, 1'b0, 36'h9A5C3E1F7},
    {3'd2, 1'b1, 36'h0FEDCBA98}, {3'd2, 1'b0, 36'h876543210},
    {3'd0, 1'b1, 36'hABCDE0123}, {3'd3, 1'b1, 36'h13579BDF0},
    {3'd3, 1'b0, 36'h2468ACE13}, {3'd4, 1'b1, 36'hF0E1D2C3B},
    {3'd4, 1'b0, 36'h5A5A0F0F1}
  };

  function automatic int in_beats(input logic [2:0] m);
    if (m == 3'd1) return 4;
    if (m == 3'd2) return 2;
    return 1;
  endfunction

  function automatic int out_beats(input logic [2:0] m);
    if (m == 3'd4) return 4;
    if (m == 3'd3) return 2;
    return 1;
  endfunction

  function automatic logic [35:0] exp_piece(input logic [35:0] word, input int i,
                                            input int nb, input logic be);
    int w, slot;
    logic [35:0] m;
    w = 36 / nb;
    slot = be ? (nb - 1 - i) : i;
    m = (36'h1 << w) - 36'h1;
    return (word >> (slot * w)) & m;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic master_reset(input logic [2:0] m, input logic be);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; big_endian = be;
    in_valid = 1'b0; pop_valid = 1'b0; push_ready = 1'b1; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mode_sel = m ^ 3'b101;   // R8: later changes must not matter
    big_endian = ~be;
  endtask

  task automatic partial_reset();
    @(negedge clk);
    prst_n = 1'b0; in_valid = 1'b0; pop_valid = 1'b0;
    @(negedge clk);
    prst_n = 1'b1;
  endtask

  // drives beats with junk above the beat width (R11)
  task automatic write_word(input string req, input logic [35:0] word,
                            input int nb, input logic be);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = exp_piece(word, i, nb, be);
      if (nb > 1) in_data = in_data | ~((36'h1 << (36 / nb)) - 36'h1);
      #1;
      chk(req, {35'd0, push_valid}, {35'd0, (i == nb - 1)});
      if (i == nb - 1) chk(req, push_data, word);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_word(input string req, input logic [35:0] word,
                           input int nb, input logic be);
    @(negedge clk);
    pop_valid = 1'b1; pop_data = word;
    #1 chk(req, {35'd0, pop_ready}, 36'd1);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (i == nb - 1) pop_valid = 1'b0;
      #1;
      chk(req, {35'd0, out_valid}, 36'd1);
      chk(req, out_data, exp_piece(word, i, nb, be));
      chk(req, {35'd0, pop_ready}, 36'd0);
    end
    @(negedge clk);
    #1;
    chk(req, {35'd0, out_valid}, 36'd0);
    chk(req, {35'd0, pop_ready}, 36'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    master_reset(3'd1, 1'b1);
    #1;
    chk("R9 in_ready", {35'd0, in_ready}, 36'd1);
    chk("R9 push_valid", {35'd0, push_valid}, 36'd0);
    chk("R9 out_valid", {35'd0, out_valid}, 36'd0);
    chk("R9 pop_ready", {35'd0, pop_ready}, 36'd1);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R11
    for (int v = 0; v < 9; v++) begin
      logic [2:0]  m;
      logic        be;
      logic [35:0] w;
      m = VEC[v][39:37]; be = VEC[v][36]; w = VEC[v][35:0];
      master_reset(m, be);
      if (m <= 3'd2) write_word("R2/R3/R4/R7 pack", w, in_beats(m), be);
      if (m == 3'd0 || m >= 3'd3) read_word("R4/R5/R6/R7 unpack", w, out_beats(m), be);
    end

    // R1 unsupported codes behave as x36 both ways
    master_reset(3'b111, 1'b1);
    write_word("R1 code7 write", 36'h123456789, 1, 1'b1);
    read_word("R1 code7 read", 36'h987654321, 1, 1'b1);
    master_reset(3'b101, 1'b0);
    write_word("R1 code5 write", 36'hFEDCBA987, 1, 1'b0);

    // R8 setting survives later input changes and a partial reset
    master_reset(3'd1, 1'b0);
    partial_reset();
    write_word("R8 kept x9 little", 36'h31415926A, 4, 1'b0);
    master_reset(3'd4, 1'b1);
    partial_reset();
    read_word("R8 kept x9-out big", 36'h27182818F, 4, 1'b1);

    // R9 partial input word dropped on partial reset
    master_reset(3'd1, 1'b1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 36'h1FF;
      @(posedge clk);
    end
    partial_reset();
    write_word("R9 no leftover", 36'h0000000AB, 4, 1'b1);
    // R9 partial input word dropped on master reset
    @(negedge clk);
    in_valid = 1'b1; in_data = 36'h1FF;
    @(posedge clk);
    master_reset(3'd1, 1'b1);
    write_word("R9 master drop", 36'h000000000, 4, 1'b1);

    // R9 partly delivered output word dropped
    master_reset(3'd4, 1'b1);
    @(negedge clk);
    pop_valid = 1'b1; pop_data = 36'hABCABCABC;
    @(negedge clk);
    pop_valid = 1'b0;
    @(negedge clk);
    partial_reset();
    #1;
    chk("R9 out dropped", {35'd0, out_valid}, 36'd0);
    chk("R9 pop ready", {35'd0, pop_ready}, 36'd1);

    // R10 input stall on last beat
    master_reset(3'd2, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 36'h00001234;
    @(negedge clk);
    in_data = 36'h00002BCD; push_ready = 1'b0;
    #1;
    chk("R10 in stalled", {35'd0, in_ready}, 36'd0);
    chk("R10 push offered", {35'd0, push_valid}, 36'd1);
    @(negedge clk);
    #1;
    chk("R10 word held", push_data, {18'h02BCD, 18'h01234});
    push_ready = 1'b1;
    #1 chk("R10 released", {35'd0, in_ready}, 36'd1);
    @(negedge clk);
    in_valid = 1'b0;
    write_word("R10 restart", 36'h3C3C3C3C3, 2, 1'b0);

    // R10 output held while reader stalls
    master_reset(3'd3, 1'b1);
    @(negedge clk);
    pop_valid = 1'b1; pop_data = 36'h5DEADBEEF; out_ready = 1'b0;
    @(negedge clk);
    pop_valid = 1'b0;
    #1 chk("R10 out first", out_data, exp_piece(36'h5DEADBEEF, 0, 2, 1'b1));
    @(negedge clk);
    #1 chk("R10 out stable", out_data, exp_piece(36'h5DEADBEEF, 0, 2, 1'b1));
    chk("R10 out valid", {35'd0, out_valid}, 36'd1);
    out_ready = 1'b1;
    @(negedge clk);
    #1 chk("R10 out second", out_data, exp_piece(36'h5DEADBEEF, 1, 2, 1'b1));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule